// File: doc/BRIEF.md
# PWM Compare Channel with Fault Shutdown

This block is one compare channel. It builds a pulse-width-modulated waveform from a free-running timer value and a period value, and both of those come from a time base outside the block. A 3-bit mode field chooses how the channel behaves. It can be switched off, it can run PWM, or it can run PWM guarded by an active-low fault pin. Software sets the duty cycle by writing a staging register. The channel moves that staged value into its working duty register only when the timer reaches the period value, so a new duty value never cuts a period short.

In guarded mode, a low level on the fault pin removes the output enable at once, without waiting for a clock, and the pad floats. A synchronised copy of the pin then sets a sticky fault bit in the control readback and raises the interrupt pulse. The fault stays latched until software writes the mode field again. Detection does not depend on the timer moving, so it keeps working while the time base is stopped in a low-power state. A parameter gives the channel index. Channels 1 to 4 watch fault pin A and channels 5 to 8 watch fault pin B.

Top module: `pwm_oc_channel`

## Requirements
- R1: Mode 3'b000 disables the channel: `pwm_oe` is 0, `pwm_out` is 0 and there is no period interrupt. In this mode a `duty_we` pulse loads `duty_wdata` straight into the working duty, which `duty_rd` shows after the next edge. Reset leaves mode 000, duty 0 and `ctrl_rd` 0.
- R2: In every mode other than 000, `duty_we` is ignored and the working duty changes only at a period end.
- R3: The period ends in a cycle where mode is 110 or 111 and `timer_cnt == period_cnt`. At the edge that closes that cycle, the staged value present before that edge is copied into the working duty.
- R4: `irq` is a one-cycle pulse in the cycle after each period end.
- R5: In modes 110 and 111, `pwm_out` is registered and follows the timer value of the previous cycle. At timer 0 it goes high if the duty is nonzero and stays low if the duty is 0. It goes low when the timer equals the duty. In every other cycle it holds. So a duty of 0 gives a constant low, and a duty larger than the period gives a constant high.
- R6: `pwm_oe` is 1 in mode 110, and in mode 111 while no fault is present or latched.
- R7: In mode 111, a low level on the selected fault pin drops `pwm_oe` in the same cycle, without waiting for a clock edge.
- R8: In mode 111, the selected fault pin passes through two synchroniser flops. The first edge at which the synchronised level is low sets `ctrl_rd[4]` and pulses `irq`. The fault bit and the forced-low `pwm_oe` stay in place after the pin returns high, until a mode write clears them. `ctrl_rd[2:0]` shows the mode.
- R9: A channel with `CH_IDX` from 1 to 4 reacts only to `fault_a_n`. A channel with `CH_IDX` from 5 to 8 reacts only to `fault_b_n`.
- R10: Fault detection and latching work while `timer_cnt` is held constant.
- R11: In mode 110, the fault pins have no effect on `pwm_oe` or on `ctrl_rd[4]`.
- R12: A period end and a fault detection can fall on the same edge. That edge gives one `irq` pulse, and both the duty copy and the fault bit take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_cnt | input | TW | Shared timer value |
| period_cnt | input | TW | Shared period value |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | New mode value |
| dbuf_we | input | 1 | Staged-duty write strobe |
| dbuf_wdata | input | TW | Staged duty value |
| duty_we | input | 1 | Direct working-duty write strobe (mode 000 only) |
| duty_wdata | input | TW | Direct working-duty value |
| fault_a_n | input | 1 | Active-low fault pin A |
| fault_b_n | input | 1 | Active-low fault pin B |
| pwm_out | output | 1 | PWM data to the pad |
| pwm_oe | output | 1 | Pad output enable; 0 floats the pad |
| irq | output | 1 | Interrupt pulse |
| ctrl_rd | output | 5 | Control readback: bit 4 fault, bit 3 zero, bits 2:0 mode |
| duty_rd | output | TW | Working duty readback |

## Verification
The period-end interrupt and the fault-detection interrupt can land on the same edge. The bench sets this up by pulling fault pin A low exactly when the timer steps to two below the period, so that after the two synchroniser flops the detection falls on the period-end edge. It then expects one `irq` pulse that is low again on the following cycle, the fault bit set, and the staged duty copied, with a behavioural model compared on every clock besides.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;
  typedef enum logic [2:0] {
    OC_OFF     = 3'b000,
    OC_PWM     = 3'b110,
    OC_PWM_FLT = 3'b111
  } oc_mode_e;

  localparam int CTRL_W  = 5;
  localparam int FLT_POS = 4;
endpackage

// File: rtl/oc_fault_sync.sv
module oc_fault_sync #(
  parameter int CH_IDX = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fault_a_n,
  input  logic fault_b_n,
  output logic raw_n,
  output logic sync_n
);
  localparam bit USE_B = (CH_IDX > 4);

  logic [1:0] stage_q;

  assign raw_n = USE_B ? fault_b_n : fault_a_n;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= 2'b11;
    else     stage_q <= {stage_q[0], raw_n};
  end

  assign sync_n = stage_q[1];

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
    $fell(stage_q[0]) |=> !sync_n); // R8
endmodule

// File: rtl/oc_duty_regs.sv
module oc_duty_regs #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          period_end,
  input  logic          mode_off,
  input  logic          buf_we,
  input  logic [TW-1:0] buf_d,
  input  logic          act_we,
  input  logic [TW-1:0] act_d,
  output logic [TW-1:0] active_duty
);
  logic [TW-1:0] stage_q;
  logic [TW-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (buf_we) stage_q <= buf_d;
      if (period_end)            act_q <= stage_q;
      else if (mode_off && act_we) act_q <= act_d;
    end
  end

  assign active_duty = act_q;

  AST_DUTY_COPY: assert property (@(posedge clk) disable iff (rst)
    period_end |=> active_duty == $past(stage_q)); // R3
  AST_DUTY_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!period_end && !mode_off) |=> $stable(active_duty)); // R2
endmodule

// File: rtl/oc_wave.sv
module oc_wave #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwm_on,
  input  logic [TW-1:0] timer,
  input  logic [TW-1:0] duty,
  output logic          wave
);
  always_ff @(posedge clk) begin
    if (rst)                wave <= 1'b0;
    else if (!pwm_on)       wave <= 1'b0;
    else if (timer == '0)   wave <= (duty != '0);
    else if (timer == duty) wave <= 1'b0;
  end

  AST_WAVE_START: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && timer == '0 && duty != '0) |=> wave); // R5
  AST_WAVE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pwm_on && timer == duty) |=> !wave); // R5
endmodule

// File: rtl/pwm_oc_channel.sv
module pwm_oc_channel
  import pwm_oc_pkg::*;
#(
  parameter int TW     = 8,
  parameter int CH_IDX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     timer_cnt,
  input  logic [TW-1:0]     period_cnt,
  input  logic              mode_we,
  input  logic [2:0]        mode_wdata,
  input  logic              dbuf_we,
  input  logic [TW-1:0]     dbuf_wdata,
  input  logic              duty_we,
  input  logic [TW-1:0]     duty_wdata,
  input  logic              fault_a_n,
  input  logic              fault_b_n,
  output logic              pwm_out,
  output logic              pwm_oe,
  output logic              irq,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [TW-1:0]     duty_rd
);
  logic [2:0] mode_q;
  logic       flt_q;
  logic       irq_q;
  logic       fault_raw_n;
  logic       fault_sync_n;
  logic       pwm_on;
  logic       guarded;
  logic       period_end;
  logic       flt_detect;

  assign pwm_on     = (mode_q[2:1] == 2'b11);
  assign guarded    = (mode_q == OC_PWM_FLT);
  assign period_end = pwm_on && (timer_cnt == period_cnt);
  assign flt_detect = guarded && !fault_sync_n && !flt_q;

  oc_fault_sync #(.CH_IDX(CH_IDX)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .fault_a_n(fault_a_n),
    .fault_b_n(fault_b_n),
    .raw_n    (fault_raw_n),
    .sync_n   (fault_sync_n)
  );

  oc_duty_regs #(.TW(TW)) u_duty (
    .clk        (clk),
    .rst        (rst),
    .period_end (period_end),
    .mode_off   (mode_q == OC_OFF),
    .buf_we     (dbuf_we),
    .buf_d      (dbuf_wdata),
    .act_we     (duty_we),
    .act_d      (duty_wdata),
    .active_duty(duty_rd)
  );

  oc_wave #(.TW(TW)) u_wave (
    .clk   (clk),
    .rst   (rst),
    .pwm_on(pwm_on),
    .timer (timer_cnt),
    .duty  (duty_rd),
    .wave  (pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= OC_OFF;
      flt_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_wdata;
      if (mode_we)         flt_q <= 1'b0;
      else if (flt_detect) flt_q <= 1'b1;
      irq_q <= period_end || (flt_detect && !mode_we);
    end
  end

  // Pad enable is combinational from the raw pin so shutdown needs no clock.
  assign pwm_oe  = pwm_on && !flt_q && !(guarded && !fault_raw_n);
  assign irq     = irq_q;
  assign ctrl_rd = {flt_q, 1'b0, mode_q};

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_q == OC_OFF) |=> (!pwm_out && !irq)); // R1
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    period_end |=> irq); // R4
  AST_FLT_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
    (guarded && !fault_raw_n) |-> !pwm_oe); // R7
  AST_FLT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (guarded && !fault_sync_n && !mode_we) |=> (ctrl_rd[FLT_POS] && !pwm_oe)); // R8
  AST_FLT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flt_q && !mode_we) |=> flt_q); // R8
  AST_UNGUARDED_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == OC_PWM) |-> pwm_oe); // R11
endmodule

// File: tb/test_pwm_oc_channel.sv
`timescale 1ns/1ps
module test_pwm_oc_channel;
  localparam int TW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic [TW-1:0] tmr = '0;
  logic [TW-1:0] per = 8'd9;
  logic          run = 1'b0;
  logic          mode_we = 1'b0;
  logic [2:0]    mode_wd = 3'b000;
  logic          dbuf_we = 1'b0;
  logic [TW-1:0] dbuf_wd = '0;
  logic          duty_we = 1'b0;
  logic [TW-1:0] duty_wd = '0;
  logic          fa = 1'b1;
  logic          fb = 1'b1;

  logic [1:0]    o_out, o_oe, o_irq;
  logic [4:0]    o_ctrl [2];
  logic [TW-1:0] o_duty [2];

  pwm_oc_channel #(.TW(TW), .CH_IDX(1)) i_pwm_oc_channel (
    .clk(clk), .rst(rst), .timer_cnt(tmr), .period_cnt(per),
    .mode_we(mode_we), .mode_wdata(mode_wd), .dbuf_we(dbuf_we), .dbuf_wdata(dbuf_wd),
    .duty_we(duty_we), .duty_wdata(duty_wd), .fault_a_n(fa), .fault_b_n(fb),
    .pwm_out(o_out[0]), .pwm_oe(o_oe[0]), .irq(o_irq[0]), .ctrl_rd(o_ctrl[0]), .duty_rd(o_duty[0]));

  pwm_oc_channel #(.TW(TW), .CH_IDX(6)) i_pwm_oc_channel_hi (
    .clk(clk), .rst(rst), .timer_cnt(tmr), .period_cnt(per),
    .mode_we(mode_we), .mode_wdata(mode_wd), .dbuf_we(dbuf_we), .dbuf_wdata(dbuf_wd),
    .duty_we(duty_we), .duty_wdata(duty_wd), .fault_a_n(fa), .fault_b_n(fb),
    .pwm_out(o_out[1]), .pwm_oe(o_oe[1]), .irq(o_irq[1]), .ctrl_rd(o_ctrl[1]), .duty_rd(o_duty[1]));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: index 0 watches pin A, index 1 watches pin B.
  int  m_mode [2], m_duty [2], m_buf [2];
  bit  m_flt [2], m_s1 [2], m_s2 [2], m_out [2], m_irq [2];
  bit  cmp_on = 1'b0;

  function automatic bit pin(int k);
    return (k == 0) ? fa : fb;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) begin
        m_mode[k] = 0; m_duty[k] = 0; m_buf[k] = 0;
        m_flt[k] = 0; m_s1[k] = 1; m_s2[k] = 1; m_out[k] = 0; m_irq[k] = 0;
      end else begin
        bit on, fin, det;
        int nduty;
        on  = (m_mode[k] == 6) || (m_mode[k] == 7);
        fin = on && (tmr == per);
        det = (m_mode[k] == 7) && !m_s2[k] && !m_flt[k];
        m_irq[k] = fin || (det && !mode_we);
        if (mode_we) m_flt[k] = 0; else if (det) m_flt[k] = 1;
        m_s2[k] = m_s1[k];
        m_s1[k] = pin(k);
        nduty = m_duty[k];
        if (fin) nduty = m_buf[k];
        else if (m_mode[k] == 0 && duty_we) nduty = duty_wd;
        if (!on) m_out[k] = 0;
        else if (tmr == 0) m_out[k] = (m_duty[k] != 0);
        else if (tmr == m_duty[k]) m_out[k] = 0;
        m_duty[k] = nduty;
        if (dbuf_we) m_buf[k] = dbuf_wd;
        if (mode_we) m_mode[k] = mode_wd;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      for (int k = 0; k < 2; k++) begin
        bit on;
        int exp_oe;
        on = (m_mode[k] == 6) || (m_mode[k] == 7);
        exp_oe = on && !m_flt[k] && !(m_mode[k] == 7 && !pin(k));
        chk("R5", "pwm_out", o_out[k], m_out[k]);
        chk("R6", "pwm_oe", o_oe[k], exp_oe);
        chk("R4", "irq", o_irq[k], m_irq[k]);
        chk("R3", "duty_rd", o_duty[k], m_duty[k]);
        chk("R8", "ctrl_rd", o_ctrl[k], {m_flt[k], 1'b0, m_mode[k][2:0]});
      end
    end
  end

  always @(negedge clk) if (run) tmr <= (tmr == per) ? '0 : tmr + 1'b1;

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wd = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic set_buf(logic [TW-1:0] d);
    @(negedge clk); dbuf_we = 1'b1; dbuf_wd = d;
    @(negedge clk); dbuf_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #50000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(posedge clk); #2;
    chk("R1", "reset ctrl", o_ctrl[0], 0);
    chk("R1", "reset oe", o_oe[0], 0);
    chk("R1", "reset duty", o_duty[0], 0);

    // R1: direct duty load while disabled
    @(negedge clk); duty_we = 1'b1; duty_wd = 8'd5;
    @(negedge clk); duty_we = 1'b0;
    chk("R1", "direct duty", o_duty[0], 5);

    set_buf(8'd3);
    set_mode(3'b110);
    run = 1'b1;
    cyc(25);
    chk("R6", "oe in 110", o_oe[0], 1);
    chk("R3", "duty after period", o_duty[0], 3);

    // R2: direct write ignored in PWM mode
    @(posedge clk); while (tmr != 8'd2) @(posedge clk);
    @(negedge clk); duty_we = 1'b1; duty_wd = 8'd7;
    @(negedge clk); duty_we = 1'b0;
    chk("R2", "duty_we ignored", o_duty[0], 3);

    // R5: zero duty gives constant low
    set_buf(8'd0);
    cyc(22);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); chk("R5", "duty 0 low", o_out[0], 0);
    end
    // R5: duty above period gives constant high
    set_buf(8'd15);
    cyc(22);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); chk("R5", "duty>period high", o_out[0], 1);
    end
    set_buf(8'd4);

    // R11: faults ignored in mode 110
    @(negedge clk); fa = 1'b0; fb = 1'b0;
    cyc(5);
    chk("R11", "oe 110 fault", o_oe[0], 1);
    chk("R11", "flt bit 110", o_ctrl[0][4], 0);
    @(negedge clk); fa = 1'b1; fb = 1'b1;

    // R7, R8, R9: guarded mode on pin A
    set_mode(3'b111);
    cyc(3);
    @(negedge clk); fa = 1'b0;
    #0.5;
    chk("R7", "immediate shutdown", o_oe[0], 0);
    chk("R9", "pin B channel unaffected", o_oe[1], 1);
    cyc(3);
    chk("R8", "fault bit set", o_ctrl[0][4], 1);
    chk("R9", "pin B channel no fault", o_ctrl[1][4], 0);
    @(negedge clk); fa = 1'b1;
    cyc(5);
    chk("R8", "oe stays low", o_oe[0], 0);
    chk("R8", "fault bit sticky", o_ctrl[0][4], 1);
    set_mode(3'b111);
    cyc(1);
    chk("R8", "cleared by mode write", o_ctrl[0][4], 0);
    chk("R8", "oe restored", o_oe[0], 1);

    // R10: detection with frozen timer, pin B
    run = 1'b0;
    @(negedge clk); fb = 1'b0;
    cyc(4);
    chk("R10", "frozen timer fault", o_ctrl[1][4], 1);
    chk("R10", "frozen timer oe", o_oe[1], 0);
    chk("R9", "pin A channel untouched", o_ctrl[0][4], 0);
    @(negedge clk); fb = 1'b1;
    set_mode(3'b111);
    run = 1'b1;
    set_buf(8'd6);

    // R12: fault detection on the period-end edge
    @(posedge clk); while (tmr != per - 8'd3) @(posedge clk);
    @(negedge clk); fa = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R12", "irq on shared edge", o_irq[0], 1);
    chk("R12", "fault bit on shared edge", o_ctrl[0][4], 1);
    chk("R12", "duty copied on shared edge", o_duty[0], 6);
    @(posedge clk); #2;
    chk("R12", "single irq pulse", o_irq[0], 0);
    @(negedge clk); fa = 1'b1;
    cyc(4);
    finish_run();
  end
endmodule